// File: doc/BRIEF.md
# Memory Interface Reset Requester

This block lives in user logic beside an external-memory-interface controller. It turns a one-cycle trigger from user logic into a reset request that the controller accepts. The controller only accepts a complete low-high-low pulse on its request line, and only while its done status is high. A level held high on that line does nothing, so the block always returns the line low after the pulse.

A trigger that arrives while done is low is held until done is high again. The pulse lasts `PULSE_CYCLES` core clock cycles, and values below two are rejected at elaboration. After the pulse the block follows the controller's done status through one fall and one rise. Done rises after every calibration, whether it passed or failed, and the block treats that rise as the end of the reset. It then raises a one-cycle complete flag.

The block assumes nothing about how long the controller takes to start the reset. It only watches done. The done input is re-timed through two flops before any decision uses it.

Top module: `mem_rst_requester`

## Requirements
- R1: While `rst_n` is low, and after it is released, `req_o`, `busy_o` and `complete_o` are 0. Asserting `rst_n` low during a pulse drops `req_o` at once.
- R2: A trigger sampled while the synchronized done is high raises `req_o` in the next cycle.
- R3: A trigger sampled while done is low sets `busy_o` but keeps `req_o` low for as long as done stays low. Once `done_i` rises, `req_o` rises on the third clock edge (two synchronizer flops plus one state register).
- R4: `req_o` stays high for exactly `PULSE_CYCLES` consecutive cycles and then returns low. `PULSE_CYCLES` is at least 2.
- R5: `busy_o` is high from the cycle after an accepted trigger until the sequence ends. It is low in the cycle in which `complete_o` is high.
- R6: After the pulse, the block waits for done to go low and then high. `complete_o` is high for exactly one cycle, on the third clock edge after `done_i` rises.
- R7: A trigger that arrives while `busy_o` is high is ignored. It produces no second pulse, either during the sequence or after it ends.
- R8: If done goes low and returns high while the pulse is still being sent, that low period still counts as the controller's response, and `complete_o` follows once done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the block |
| trig_i | input | 1 | One-cycle request from user logic |
| done_i | input | 1 | Controller done status, asynchronous to `clk` |
| req_o | output | 1 | Reset request pulse to the controller |
| busy_o | output | 1 | A request sequence is in progress |
| complete_o | output | 1 | One-cycle flag marking the end of a sequence |

## Verification
The properties assume that done moves as a real controller's would. It is stable for at least a few cycles at a time, and after each pulse it makes one low period followed by a rise. The properties also assume that `trig_i` is a single-cycle strobe. The stimulus keeps to this: it changes done only on falling clock edges and holds every done level for at least two cycles. The done low period that answers each pulse lasts four cycles, or two cycles when it falls inside the pulse. Extra triggers are sent only while a sequence is already running, which is where the ignore rule applies.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_PULSE,
    ST_WAIT_LOW,
    ST_WAIT_HIGH
  } mrr_state_e;
endpackage

// File: rtl/mrr_sync.sv
module mrr_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mrr_pulse_timer.sv
module mrr_pulse_timer #(
  parameter int PULSE_CYCLES = 4,
  localparam int CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = '0;
    if (run_i && (cnt_q != LAST)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mrr_seq.sv
module mrr_seq
  import mrr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic done_s_i,
  input  logic t_last_i,
  output logic t_run_o,
  output logic req_o,
  output logic busy_o,
  output logic complete_o
);
  mrr_state_e state_q, state_d;
  logic seen_low_q, seen_low_d;
  logic cmpl_q, cmpl_d;

  always_comb begin
    state_d    = state_q;
    seen_low_d = seen_low_q;
    cmpl_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        seen_low_d = 1'b0;
        if (trig_i) state_d = done_s_i ? ST_PULSE : ST_ARMED;
      end
      ST_ARMED: if (done_s_i) state_d = ST_PULSE;
      ST_PULSE: begin
        if (!done_s_i) seen_low_d = 1'b1;
        if (t_last_i)  state_d    = ST_WAIT_LOW;
      end
      ST_WAIT_LOW: if (seen_low_q || !done_s_i) state_d = ST_WAIT_HIGH;
      ST_WAIT_HIGH: if (done_s_i) begin
        state_d = ST_IDLE;
        cmpl_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      seen_low_q <= 1'b0;
      cmpl_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      seen_low_q <= seen_low_d;
      cmpl_q     <= cmpl_d;
    end
  end

  assign t_run_o    = (state_q == ST_PULSE);
  assign req_o      = (state_q == ST_PULSE);
  assign busy_o     = (state_q != ST_IDLE);
  assign complete_o = cmpl_q;
endmodule

// File: rtl/mem_rst_requester.sv
module mem_rst_requester #(
  parameter int PULSE_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic done_i,
  output logic req_o,
  output logic busy_o,
  output logic complete_o
);
  if (PULSE_CYCLES < 2) begin : g_bad_width
    $error("PULSE_CYCLES must be at least 2");
  end

  logic rst_int_n;
  logic done_s;
  logic t_run, t_last;

  mrr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_int_n)
  );

  mrr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) done_sync_i (
    .clk(clk), .rst_n(rst_int_n), .d_i(done_i), .q_o(done_s)
  );

  mrr_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_int_n), .run_i(t_run), .last_o(t_last)
  );

  mrr_seq seq_i (
    .clk(clk), .rst_n(rst_int_n), .trig_i(trig_i), .done_s_i(done_s),
    .t_last_i(t_last), .t_run_o(t_run), .req_o(req_o),
    .busy_o(busy_o), .complete_o(complete_o)
  );
endmodule

// File: rtl/mrr_checker.sv
module mrr_checker #(
  parameter int PULSE_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_o,
  input logic busy_o,
  input logic complete_o,
  input logic done_s
);
  logic [15:0] run_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len_q <= '0;
    else if (req_o) run_len_q <= (run_len_q == 16'hFFFF) ? run_len_q : run_len_q + 1'b1;
    else            run_len_q <= '0;
  end

  // R2 / R3: the request rises only after synchronized done was high
  a_r3_rise_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(done_s));

  // R4: at least two cycles high
  a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |=> req_o);

  // R4: never longer than the programmed width
  a_r4_max_width: assert property (@(posedge clk) disable iff (!rst_n)
    run_len_q <= 16'(PULSE_CYCLES));

  // R4: full-width pulse when it falls
  a_r4_exact_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> run_len_q == 16'(PULSE_CYCLES));

  // R5: busy covers the pulse
  a_r5_busy_during_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> busy_o);

  // R5: busy low when complete fires
  a_r5_idle_at_complete: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |-> !busy_o);

  // R6: complete is a single cycle and follows synchronized done high
  a_r6_single_complete: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |=> !complete_o);

  a_r6_complete_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(complete_o) |-> $past(done_s));
endmodule

bind mem_rst_requester mrr_checker #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .busy_o(busy_o),
  .complete_o(complete_o), .done_s(done_s)
);

// File: tb/mem_rst_requester_tb_top.sv
`timescale 1ns/1ps
module mem_rst_requester_tb_top;
  localparam int P = 4;
  // [7] done low at trigger, [6] extra trigger mid-pulse,
  // [5] done drop inside the pulse, [3:0] cycles done stays low before ready
  localparam logic [7:0] VEC [6] = '{8'h00, 8'h83, 8'h40, 8'h20, 8'hC5, 8'hA2};

  logic clk, rst_n, trig_i, done_i, req_o, busy_o, complete_o;
  int n_chk, n_fail;

  mem_rst_requester #(.PULSE_CYCLES(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .done_i(done_i),
    .req_o(req_o), .busy_o(busy_o), .complete_o(complete_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int width, seen;
    logic e_low, e_mid, e_drop;
    int e_wait;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; trig_i = 1'b0; done_i = 1'b1;
    repeat (3) tick();
    check(!req_o && !busy_o && !complete_o, "R1 reset state", {req_o, busy_o, complete_o}, 0);
    rst_n = 1'b1;
    repeat (5) tick();
    check(!req_o && !busy_o && !complete_o, "R1 after release", {req_o, busy_o, complete_o}, 0);

    for (int v = 0; v < 6; v++) begin
      e_low = VEC[v][7]; e_mid = VEC[v][6]; e_drop = VEC[v][5]; e_wait = int'(VEC[v][3:0]);
      if (e_low) begin done_i = 1'b0; repeat (4) tick(); end
      trig_i = 1'b1; tick(); trig_i = 1'b0;
      if (!e_low) begin
        check(req_o == 1'b1, "R2 req next cycle", req_o, 1);
        check(busy_o == 1'b1, "R5 busy after trigger", busy_o, 1);
      end else begin
        check(req_o == 1'b0 && busy_o == 1'b1, "R3 held while done low", {req_o, busy_o}, 1);
        for (int w = 0; w < e_wait; w++) begin
          tick();
          check(req_o == 1'b0, "R3 no req while done low", req_o, 0);
        end
        done_i = 1'b1;
        tick(); tick();
        check(req_o == 1'b0, "R3 not before sync", req_o, 0);
        tick();
        check(req_o == 1'b1, "R3 rise on third edge", req_o, 1);
      end
      width = 0;
      while (req_o && width < 20) begin
        if (e_drop && width == 0) done_i = 1'b0;
        if (e_drop && width == 2) done_i = 1'b1;
        if (e_mid && width == 1) trig_i = 1'b1;
        width++;
        tick();
        trig_i = 1'b0;
      end
      check(width == P, "R4 pulse width", width, P);
      if (!e_drop) begin
        tick();
        check(busy_o && !complete_o, "R6 waits for done", {busy_o, complete_o}, 2);
        done_i = 1'b0;
        for (int w = 0; w < 4; w++) tick();
        check(busy_o && !complete_o, "R6 waits for done rise", {busy_o, complete_o}, 2);
        done_i = 1'b1;
        tick(); tick();
        check(!complete_o, "R6 not early", complete_o, 0);
        tick();
        check(complete_o == 1'b1, "R6 complete on third edge", complete_o, 1);
        check(busy_o == 1'b0, "R5 busy low at complete", busy_o, 0);
        tick();
        check(!complete_o, "R6 one cycle", complete_o, 0);
      end else begin
        seen = 0;
        for (int w = 0; w < 12; w++) begin
          if (complete_o) seen++;
          tick();
        end
        check(seen == 1, "R8 drop inside pulse counted", seen, 1);
      end
      seen = 0;
      for (int w = 0; w < 6; w++) begin
        if (req_o || busy_o) seen++;
        tick();
      end
      check(seen == 0, e_mid ? "R7 mid trigger ignored" : "R5 idle after", seen, 0);
    end

    // R1: reset in the middle of a pulse drops the request at once
    trig_i = 1'b1; tick(); trig_i = 1'b0;
    tick();
    check(req_o == 1'b1, "R1 pulse before reset", req_o, 1);
    rst_n = 1'b0; #1;
    check(!req_o && !busy_o, "R1 async drop", {req_o, busy_o}, 0);
    tick(); rst_n = 1'b1;
    repeat (6) tick();
    check(!req_o && !busy_o && !complete_o, "R1 clean after reset", {req_o, busy_o, complete_o}, 0);

    // R7: level held high starts only one sequence
    trig_i = 1'b1;
    width = 0;
    for (int w = 0; w < 8; w++) begin
      tick();
      if (req_o) width++;
    end
    trig_i = 1'b0;
    check(width == P, "R7 held trigger one pulse", width, P);
    done_i = 1'b0; repeat (4) tick(); done_i = 1'b1; repeat (4) tick();
    check(!busy_o && !req_o, "R7 back to idle", {busy_o, req_o}, 0);
    finish_run();
  end
endmodule